// File: doc/BRIEF.md
# Filtered Quadrature Counter with Event Timestamp

This block is one channel of an incremental encoder interface. Three encoder lines (A, B and index) and one index-mask line enter through two-flop synchronisers. A, B and index then pass through a sampled digital filter whose sample rate and run length are programmable. The filtered A/B pair drives a 16-bit position count, either as a 4x quadrature decoder or as a pulse-plus-direction counter. The filter strips short noise spikes, such as those coupled in from motor drive switching, before they can reach the counter.

Each time the count takes a step, the block copies the current value of a free-running 16-bit timebase into the upper half of the count word. Software divides the change in count by the change in timestamp to estimate velocity at low speeds. An index event can clear the count, capture it into a latch, or both. It can be qualified by the A·B level, by an external mask line of selectable polarity, and by a one-shot option that disarms itself after the first event. A control word holds the configuration, a sticky error flag for illegal A/B transitions, the latched count and the live synchronised input levels.

Top module: `quad_ts_counter`

## Requirements
- R1: After reset, `countWord` and `ctlWord` read all zeros while every input is low.
- R2: In quadrature mode (control bit 10 = 0), each filtered change of exactly one of A or B moves the count by one. The filtered (A,B) sequence 00→10→11→01→00 counts up, the reverse order counts down, and the count wraps modulo 2^16 (0 minus one is 0xFFFF).
- R3: In quadrature mode, when A and B change in the same filtered sample, the count does not move and control bit 15 sets. It stays set until a control write with bit 15 = 1.
- R4: In up/down mode (control bit 10 = 1), each filtered rising edge of A counts up when filtered B is high and down when B is low. Changes of B alone do not count.
- R5: A filtered input adopts a new level only after 3 consecutive samples (control bit 11 = 0) or 15 consecutive samples (bit 11 = 1) agree on it. Shorter excursions are ignored.
- R6: Filter samples are taken once every `filtRate`+2 clocks. When bit 11 of `filtRate` is set, a sample is taken on every clock.
- R7: A 16-bit timebase advances once every `tsDiv`+2 clocks, or on every clock when bit 15 of `tsDiv` is set. On each count step, `countWord[31:16]` takes the timebase value, and between steps it holds.
- R8: A pulse on `cntWrEn` zeroes `countWord[15:0]` at the next clock edge and leaves the timestamp unchanged.
- R9: An index event is qualifying when all three of these hold. First, the filtered index has an edge into its active level: rising when control bit 3 = 1, falling when bit 3 = 0. Second, when bit 9 = 1, the synchronised `idxMask` equals bit 8. Third, when bit 7 = 1, filtered A AND B equals bit 14.
- R10: On a qualifying index, bit 4 = 1 copies the count into `ctlWord[31:16]` and bit 5 = 1 zeroes the count. With both set, the latch receives the value the count held before it was cleared.
- R11: When control bit 6 = 1, a qualifying index that is acted on also clears control bits 5 and 4. Later index events then have no effect on the count.
- R12: `ctlWord[2:0]` show the synchronised raw {index, B, A} levels two clocks after the pins. Bits 14 and 11..3 read back as written, and bits 13..12 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Encoder channel A (raw) |
| encB | input | 1 | Encoder channel B (raw) |
| encIdx | input | 1 | Encoder index (raw) |
| idxMask | input | 1 | External index mask level |
| filtRate | input | 12 | Filter sample divider; MSB set = every clock |
| tsDiv | input | 16 | Timebase divider; MSB set = every clock |
| cntWrEn | input | 1 | Clears the count |
| ctlWrEn | input | 1 | Writes the control bits |
| ctlWrData | input | 16 | Control write data; bit 15 = 1 clears the error flag |
| countWord | output | 32 | {timestamp of last step, count} |
| ctlWord | output | 32 | {latched count, error, control bits, live idx, B, A} |

## Verification
The assertions assume that `cntWrEn` and `ctlWrEn` are single-cycle strobes sampled at the clock, and that a control write does not coincide with a hardware error set or one-shot disarm. Under those assumptions, the sticky flag and the one-shot clearing are attributable to one cause. They also assume that the divider inputs are held steady around the windows where exact timestamp differences are measured. The stimulus changes encoder lines only at the falling clock edge, and holds each level well beyond the worst-case filter window before the next change. Strobes are spaced apart from encoder edges, and divider settings are changed only while the encoder lines are idle.

// File: rtl/qc_pkg.sv
package qc_pkg;
  // control word bit positions (software decodes these)
  localparam int CTL_ERR     = 15;
  localparam int CTL_ABPOL   = 14;
  localparam int CTL_LONGF   = 11;
  localparam int CTL_UPDN    = 10;
  localparam int CTL_USEMASK = 9;
  localparam int CTL_MASKPOL = 8;
  localparam int CTL_GATE    = 7;
  localparam int CTL_ONCE    = 6;
  localparam int CTL_CLR     = 5;
  localparam int CTL_LAT     = 4;
  localparam int CTL_IPOL    = 3;
  localparam logic [15:0] CTL_WR_MASK = 16'h4FF8;

  // input lane indices
  localparam int IN_A    = 0;
  localparam int IN_B    = 1;
  localparam int IN_IDX  = 2;
  localparam int IN_MASK = 3;
  localparam int NUM_IN   = 4;
  localparam int NUM_FILT = 3;

  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic idxClear;
    logic idxLatch;
    logic setErr;
  } qcStrobe_t;
endpackage

// File: rtl/qc_ratediv.sv
module qc_ratediv #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] divisor,
  output logic         tick
);
  logic [W-1:0] phase;
  logic         bypass;

  assign bypass = divisor[W-1];
  assign tick   = bypass | (phase >= divisor + W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + W'(1);
  end
endmodule

// File: rtl/qc_filter.sv
module qc_filter #(
  parameter int SHORT_LEN = 3,
  parameter int LONG_LEN  = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  logic longMode,
  input  logic din,
  output logic dout
);
  localparam int RUN_W = $clog2(LONG_LEN + 1);

  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] runLimit;

  assign runLimit = longMode ? RUN_W'(LONG_LEN - 1) : RUN_W'(SHORT_LEN - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run  <= '0;
      dout <= 1'b0;
    end else if (sampleEn) begin
      if (din == dout) begin
        run <= '0;
      end else if (run >= runLimit) begin
        dout <= din;
        run  <= '0;
      end else begin
        run <= run + RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/qc_datapath.sv
module qc_datapath
  import qc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TS_W   = 16,
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] rawIn,
  input  logic [RATE_W-1:0] filtRate,
  input  logic [TS_W-1:0]   tsDiv,
  input  logic              longFilt,
  input  logic              cntClear,
  input  qcStrobe_t         strobe,
  output logic [NUM_IN-1:0] syncIn,
  output logic [NUM_FILT-1:0] filtIn,
  output logic [CNT_W-1:0]  count,
  output logic [TS_W-1:0]   stamp,
  output logic [CNT_W-1:0]  latched
);
  logic [NUM_IN-1:0] meta;
  logic              sampleTick;
  logic              tsTick;
  logic [TS_W-1:0]   tsCount;
  logic              zeroCount;
  logic              stepAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= '0;
      syncIn <= '0;
    end else begin
      meta   <= rawIn;
      syncIn <= meta;
    end
  end

  qc_ratediv #(.W(RATE_W)) uSampleDiv (
    .clk(clk), .rstN(rstN), .divisor(filtRate), .tick(sampleTick)
  );

  for (genvar i = 0; i < NUM_FILT; i++) begin : gFilt
    qc_filter uFilt (
      .clk(clk), .rstN(rstN), .sampleEn(sampleTick), .longMode(longFilt),
      .din(syncIn[i]), .dout(filtIn[i])
    );
  end

  qc_ratediv #(.W(TS_W)) uTsDiv (
    .clk(clk), .rstN(rstN), .divisor(tsDiv), .tick(tsTick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       tsCount <= '0;
    else if (tsTick) tsCount <= tsCount + TS_W'(1);
  end

  assign zeroCount = cntClear | strobe.idxClear;
  assign stepAny   = strobe.stepUp | strobe.stepDn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      stamp   <= '0;
      latched <= '0;
    end else begin
      if (strobe.idxLatch) latched <= count;
      if (zeroCount) begin
        count <= '0;
      end else if (stepAny) begin
        count <= strobe.stepUp ? count + CNT_W'(1) : count - CNT_W'(1);
        stamp <= tsCount;
      end
    end
  end
endmodule

// File: rtl/qc_control.sv
module qc_control
  import qc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_FILT-1:0] filtIn,
  input  logic                maskIn,
  input  logic                ctlWrEn,
  input  logic [15:0]         ctlWrData,
  output qcStrobe_t           strobe,
  output logic [15:0]         ctlBits
);
  logic [15:0] ctlReg;
  logic        errFlag;
  logic        prevA, prevB, prevIdx;
  logic        fA, fB, fIdx;
  logic        aChg, bChg;
  logic        idxEdge, maskOk, gateOk, qualIdx, actIdx;

  assign fA   = filtIn[IN_A];
  assign fB   = filtIn[IN_B];
  assign fIdx = filtIn[IN_IDX];
  assign aChg = fA ^ prevA;
  assign bChg = fB ^ prevB;

  always_comb begin
    strobe = '0;
    if (ctlReg[CTL_UPDN]) begin
      if (fA & ~prevA) begin
        strobe.stepUp = fB;
        strobe.stepDn = ~fB;
      end
    end else begin
      if (aChg & bChg) begin
        strobe.setErr = 1'b1;
      end else if (aChg) begin
        strobe.stepUp = (fA != fB);
        strobe.stepDn = (fA == fB);
      end else if (bChg) begin
        strobe.stepUp = (fA == fB);
        strobe.stepDn = (fA != fB);
      end
    end
    idxEdge = ctlReg[CTL_IPOL] ? (fIdx & ~prevIdx) : (~fIdx & prevIdx);
    maskOk  = ~ctlReg[CTL_USEMASK] | (maskIn == ctlReg[CTL_MASKPOL]);
    gateOk  = ~ctlReg[CTL_GATE] | ((fA & fB) == ctlReg[CTL_ABPOL]);
    qualIdx = idxEdge & maskOk & gateOk;
    actIdx  = qualIdx & (ctlReg[CTL_CLR] | ctlReg[CTL_LAT]);
    strobe.idxClear = qualIdx & ctlReg[CTL_CLR];
    strobe.idxLatch = qualIdx & ctlReg[CTL_LAT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA   <= 1'b0;
      prevB   <= 1'b0;
      prevIdx <= 1'b0;
      ctlReg  <= '0;
      errFlag <= 1'b0;
    end else begin
      prevA   <= fA;
      prevB   <= fB;
      prevIdx <= fIdx;
      if (strobe.setErr)                     errFlag <= 1'b1;
      else if (ctlWrEn && ctlWrData[CTL_ERR]) errFlag <= 1'b0;
      if (ctlWrEn) begin
        ctlReg <= ctlWrData & CTL_WR_MASK;
      end else if (actIdx && ctlReg[CTL_ONCE]) begin
        ctlReg[CTL_CLR] <= 1'b0;
        ctlReg[CTL_LAT] <= 1'b0;
      end
    end
  end

  always_comb begin
    ctlBits          = ctlReg;
    ctlBits[CTL_ERR] = errFlag;
  end
endmodule

// File: rtl/quad_ts_counter.sv
module quad_ts_counter
  import qc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TS_W   = 16,
  parameter int RATE_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 encA,
  input  logic                 encB,
  input  logic                 encIdx,
  input  logic                 idxMask,
  input  logic [RATE_W-1:0]    filtRate,
  input  logic [TS_W-1:0]      tsDiv,
  input  logic                 cntWrEn,
  input  logic                 ctlWrEn,
  input  logic [15:0]          ctlWrData,
  output logic [TS_W+CNT_W-1:0] countWord,
  output logic [CNT_W+15:0]    ctlWord
);
  qcStrobe_t           strobe;
  logic [15:0]         ctlBits;
  logic [NUM_IN-1:0]   rawIn, syncIn;
  logic [NUM_FILT-1:0] filtIn;
  logic [CNT_W-1:0]    count, latched;
  logic [TS_W-1:0]     stamp;

  assign rawIn = {idxMask, encIdx, encB, encA};

  qc_control uCtl (
    .clk(clk), .rstN(rstN), .filtIn(filtIn), .maskIn(syncIn[IN_MASK]),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .strobe(strobe), .ctlBits(ctlBits)
  );

  qc_datapath #(.CNT_W(CNT_W), .TS_W(TS_W), .RATE_W(RATE_W)) uDp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .filtRate(filtRate), .tsDiv(tsDiv),
    .longFilt(ctlBits[CTL_LONGF]), .cntClear(cntWrEn), .strobe(strobe),
    .syncIn(syncIn), .filtIn(filtIn), .count(count), .stamp(stamp), .latched(latched)
  );

  assign countWord = {stamp, count};
  assign ctlWord   = {latched, ctlBits[15:3], syncIn[IN_IDX], syncIn[IN_B], syncIn[IN_A]};
endmodule

// File: rtl/qc_checker.sv
module qc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cntWrEn,
  input logic        ctlWrEn,
  input logic [15:0] ctlWrData,
  input logic [31:0] countWord,
  input logic [31:0] ctlWord
);
  // R8: a clear strobe leaves a zero count
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (countWord[15:0] == 16'd0));

  // R2: the count moves by at most one per clock unless it is zeroed
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (countWord[15:0] == $past(countWord[15:0]) ||
              countWord[15:0] == $past(countWord[15:0]) + 16'd1 ||
              countWord[15:0] == $past(countWord[15:0]) - 16'd1 ||
              countWord[15:0] == 16'd0));

  // R3: the error flag is sticky until software clears it
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWord[15] && !(ctlWrEn && ctlWrData[15])) |=> ctlWord[15]);

  // R7: the timestamp moves only together with a count change
  p_stamp_with_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(countWord[31:16]) |-> !$stable(countWord[15:0]));

  // R10: the latch changes only while latching is armed
  p_latch_armed_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlWord[31:16]) |-> $past(ctlWord[4]));

  // R11: hardware disarm of clear-on-index only happens in one-shot mode
  p_once_disarm_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctlWord[5]) && !$past(ctlWrEn)) |-> $past(ctlWord[6]));
endmodule

bind quad_ts_counter qc_checker uChk (
  .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .ctlWrEn(ctlWrEn),
  .ctlWrData(ctlWrData), .countWord(countWord), .ctlWord(ctlWord)
);

// File: tb/quad_ts_counter_test.sv
module quad_ts_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encA = 1'b0, encB = 1'b0, encIdx = 1'b0, idxMask = 1'b0;
  logic [11:0] filtRate = 12'h800;
  logic [15:0] tsDiv = 16'h8000;
  logic        cntWrEn = 1'b0, ctlWrEn = 1'b0;
  logic [15:0] ctlWrData = 16'h0;
  logic [31:0] countWord, ctlWord;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] ctlVal = 16'h0;
  logic [15:0] s1, s2, sMid;

  always #2.5 clk = ~clk;

  quad_ts_counter uut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .idxMask(idxMask), .filtRate(filtRate), .tsDiv(tsDiv), .cntWrEn(cntWrEn),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .countWord(countWord), .ctlWord(ctlWord)
  );

  typedef struct packed {
    logic        a;
    logic        b;
    logic [15:0] cnt;
  } vec_t;

  // quadrature walk from count 0: up four, down four, then below zero
  localparam vec_t VECS [12] = '{
    '{1'b1, 1'b0, 16'd1},    '{1'b1, 1'b1, 16'd2},    '{1'b0, 1'b1, 16'd3},
    '{1'b0, 1'b0, 16'd4},    '{1'b0, 1'b1, 16'd3},    '{1'b1, 1'b1, 16'd2},
    '{1'b1, 1'b0, 16'd1},    '{1'b0, 1'b0, 16'd0},    '{1'b0, 1'b1, 16'hFFFF},
    '{1'b1, 1'b1, 16'hFFFE}, '{1'b1, 1'b0, 16'hFFFD}, '{1'b0, 1'b0, 16'hFFFC}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic ctlWrite(input logic [15:0] v);
    @(negedge clk);
    ctlWrEn = 1'b1;
    ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
    ctlWrData = 16'h0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clearCount();
    @(negedge clk);
    cntWrEn = 1'b1;
    @(negedge clk);
    cntWrEn = 1'b0;
  endtask

  task automatic setAB(input logic a, input logic b);
    @(negedge clk);
    encA = a;
    encB = b;
    settle();
  endtask

  task automatic pulseIdx();
    @(negedge clk); encIdx = 1'b1; settle();
    @(negedge clk); encIdx = 1'b0; settle();
  endtask

  task automatic glitchA(input logic lvl, input int len);
    @(negedge clk); encA = lvl;
    repeat (len) @(negedge clk);
    encA = ~lvl;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 count word after reset", countWord, 32'h0);
    check("R1 control word after reset", ctlWord, 32'h0);

    // R2: table-driven quadrature walk
    for (int i = 0; i < 12; i++) begin
      setAB(VECS[i].a, VECS[i].b);
      check($sformatf("R2 quadrature step %0d", i), {16'h0, countWord[15:0]}, {16'h0, VECS[i].cnt});
    end

    // R8: clear keeps timestamp
    s1 = countWord[31:16];
    clearCount();
    check("R8 count cleared", {16'h0, countWord[15:0]}, 32'h0);
    check("R8 timestamp kept", {16'h0, countWord[31:16]}, {16'h0, s1});

    // R3: simultaneous A/B change
    setAB(1'b1, 1'b1);
    check("R3 no count on illegal change", {16'h0, countWord[15:0]}, 32'h0);
    check("R3 error flag set", {31'h0, ctlWord[15]}, 32'h1);
    setAB(1'b0, 1'b0);
    check("R3 error flag held", {31'h0, ctlWord[15]}, 32'h1);
    ctlWrite(16'h8000);
    check("R3 error flag cleared by write", {31'h0, ctlWord[15]}, 32'h0);

    // R4: up/down mode
    ctlVal = 16'h0400;
    ctlWrite(ctlVal);
    setAB(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      setAB(1'b1, 1'b1);
      setAB(1'b0, 1'b1);
    end
    check("R4 three up pulses", {16'h0, countWord[15:0]}, 32'd3);
    setAB(1'b0, 1'b0);
    check("R4 direction change alone ignored", {16'h0, countWord[15:0]}, 32'd3);
    setAB(1'b1, 1'b0);
    setAB(1'b0, 1'b0);
    check("R4 down pulse", {16'h0, countWord[15:0]}, 32'd2);
    ctlVal = 16'h0;
    ctlWrite(ctlVal);
    clearCount();

    // R5: filter length
    glitchA(1'b1, 2);
    check("R5 2-sample glitch rejected", {16'h0, countWord[15:0]}, 32'd0);
    setAB(1'b1, 1'b0);
    check("R5 steady level accepted", {16'h0, countWord[15:0]}, 32'd1);
    ctlVal = 16'h0800;
    ctlWrite(ctlVal);
    glitchA(1'b0, 10);
    check("R5 10-sample glitch rejected in long mode", {16'h0, countWord[15:0]}, 32'd1);
    setAB(1'b0, 1'b0);
    check("R5 long mode accepts steady level", {16'h0, countWord[15:0]}, 32'd0);
    ctlVal = 16'h0;
    ctlWrite(ctlVal);

    // R6: slower sample rate rejects an 18-clock glitch
    @(negedge clk); filtRate = 12'd8;
    glitchA(1'b1, 18);
    check("R6 glitch rejected at divide-by-10", {16'h0, countWord[15:0]}, 32'd0);
    setAB(1'b1, 1'b0);
    check("R6 steady level accepted at divide-by-10", {16'h0, countWord[15:0]}, 32'd1);
    setAB(1'b0, 1'b0);
    @(negedge clk); filtRate = 12'h800;

    // R7: timestamp spacing, timebase every clock
    @(negedge clk); encA = 1'b1;
    repeat (50) @(negedge clk); sMid = countWord[31:16];
    repeat (50) @(negedge clk); s1 = countWord[31:16];
    check("R7 timestamp held between steps", {16'h0, s1}, {16'h0, sMid});
    encB = 1'b1;
    repeat (100) @(negedge clk); s2 = countWord[31:16];
    check("R7 stamp delta at divide-by-one", {16'h0, s2 - s1}, 32'd100);
    // timebase every 5 clocks
    tsDiv = 16'd3;
    repeat (10) @(negedge clk);
    encA = 1'b0;
    repeat (100) @(negedge clk); s1 = countWord[31:16];
    encB = 1'b0;
    repeat (100) @(negedge clk); s2 = countWord[31:16];
    check("R7 stamp delta at divide-by-five", {16'h0, s2 - s1}, 32'd20);
    check("R2 four steps during timestamp test", {16'h0, countWord[15:0]}, 32'd4);
    tsDiv = 16'h8000;
    clearCount();

    // R10: clear and latch on index
    setAB(1'b1, 1'b0);
    setAB(1'b1, 1'b1);
    ctlVal = 16'h0038;
    ctlWrite(ctlVal);
    pulseIdx();
    check("R10 count cleared on index", {16'h0, countWord[15:0]}, 32'd0);
    check("R10 latch holds pre-clear count", {16'h0, ctlWord[31:16]}, 32'd2);
    check("R10 arm bits stay set", {30'h0, ctlWord[5:4]}, 32'd3);
    setAB(1'b0, 1'b1);

    // R9: mask qualification
    ctlVal = 16'h0338;
    ctlWrite(ctlVal);
    pulseIdx();
    check("R9 masked index leaves count", {16'h0, countWord[15:0]}, 32'd1);
    check("R9 masked index leaves latch", {16'h0, ctlWord[31:16]}, 32'd2);
    @(negedge clk); idxMask = 1'b1;
    pulseIdx();
    check("R9 unmasked index clears", {16'h0, countWord[15:0]}, 32'd0);
    check("R9 unmasked index latches", {16'h0, ctlWord[31:16]}, 32'd1);

    // R9: A.B gating
    ctlVal = 16'h43B8;
    ctlWrite(ctlVal);
    setAB(1'b0, 1'b0);
    setAB(1'b1, 1'b0);
    pulseIdx();
    check("R9 index gated off by A.B", {16'h0, countWord[15:0]}, 32'd2);
    setAB(1'b1, 1'b1);
    pulseIdx();
    check("R9 index passes gate with A.B high", {16'h0, countWord[15:0]}, 32'd0);
    check("R9 gated index latch", {16'h0, ctlWord[31:16]}, 32'd3);

    // R9: active-low index acts on falling edge
    setAB(1'b0, 1'b1);
    ctlVal = 16'h0030;
    ctlWrite(ctlVal);
    @(negedge clk); encIdx = 1'b1; settle();
    check("R9 rising edge ignored when active low", {16'h0, countWord[15:0]}, 32'd1);
    @(negedge clk); encIdx = 1'b0; settle();
    check("R9 falling edge acts when active low", {16'h0, countWord[15:0]}, 32'd0);

    // R11: one-shot
    setAB(1'b0, 1'b0);
    ctlVal = 16'h0078;
    ctlWrite(ctlVal);
    pulseIdx();
    check("R11 first index clears", {16'h0, countWord[15:0]}, 32'd0);
    check("R11 arm bits dropped", {29'h0, ctlWord[6:4]}, 32'b100);
    setAB(1'b1, 1'b0);
    pulseIdx();
    check("R11 second index ignored", {16'h0, countWord[15:0]}, 32'd1);

    // R12: live levels and readback
    @(negedge clk); encIdx = 1'b1; encB = 1'b0; encA = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 live idx/B/A", {29'h0, ctlWord[2:0]}, 32'b101);
    ctlWrite(16'h7FF8);
    check("R12 control readback", {16'h0, ctlWord[15:3], 3'b000}, 32'h4FF8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule